// File: doc/BRIEF.md
# 32-bit Instruction Decoder with Immediate Generation

This block turns one 32-bit instruction word into the control and operand-select signals that a single-cycle or pipelined datapath needs. It is purely combinational: a new word on the input gives a fully settled decode on the outputs in the same cycle. The block holds no state, so it has no states or transitions to list.

The word is cut into fixed-position fields. The 6-bit major opcode sorts it into one of three layouts: register-register, register-immediate or long jump. For the register-register layout, the 6-bit function code picks the operation. The decoder produces:

- the two register read addresses and the destination address with its write enable;
- a 4-bit ALU operation, an immediate-operand select and a shift-distance path;
- a 32-bit immediate, which is sign-extended, zero-extended or placed in the upper half;
- one-hot control flags for load, store, branch-if-equal, branch-if-not-equal and jump;
- an illegal-instruction flag that silences every side effect.

Top module: `insn32_decoder`

## Requirements
- R1: The fields are taken from fixed positions. `rs_addr_o` is bits [25:21], `rt_addr_o` is [20:16], `shamt_o` is [10:6] and `jump_index_o` is [25:0]. This holds for every input word.
- R2: `fmt_o` is 0 (register layout) when the opcode [31:26] is 0, 2 (jump layout) when the opcode is 2, and 1 (immediate layout) for every other opcode.
- R3: For opcode 0 with a supported function code, `reg_we_o` is 1, `wr_addr_o` is bits [15:11] and `alu_src_imm_o` is 0. The function code [5:0] maps to `alu_op_o` as follows: 32→0 (add), 34→1 (subtract), 36→2 (and), 37→3 (or), 39→4 (nor), 42→5 (set-less-than), 0→6 (shift left), 2→7 (shift right logical).
- R4: `use_shamt_o` is 1 only for function codes 0 and 2 under opcode 0. It is 0 for every other word.
- R5: For the immediate layout, `wr_addr_o` is bits [20:16]. `reg_we_o` and `alu_src_imm_o` are both 1 for these opcodes and ALU operations: 8 (add, op 0), 10 (set-less-than, op 5), 12 (and, op 2), 13 (or, op 3), 14 (xor, op 8), 15 (load-upper, op 9) and 35 (load word, op 0).
- R6: `imm_o` is bits [15:0] sign-extended to 32 bits for every opcode other than 12, 13, 14 and 15. This includes branches, loads, stores and illegal words.
- R7: For opcodes 12, 13 and 14, `imm_o` is bits [15:0] zero-extended, so `imm_o[31:16]` is 0.
- R8: For opcode 15, `imm_o` is bits [15:0] shifted into [31:16], with [15:0] zero.
- R9: Opcode 35 sets `mem_rd_o`. Opcode 43 sets `mem_wr_o` and `alu_src_imm_o`, with `alu_op_o` 0 and `reg_we_o` 0. At most one of the load, store, branch and jump flags is ever 1.
- R10: Opcode 4 sets `br_eq_o` and opcode 5 sets `br_ne_o`. Both use `alu_op_o` 1, `alu_src_imm_o` 0 and `reg_we_o` 0.
- R11: Opcode 2 sets `jump_o`, with `reg_we_o`, `mem_rd_o` and `mem_wr_o` all 0.
- R12: An unsupported opcode, or an unsupported function code under opcode 0, sets `illegal_o`. It forces `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `br_eq_o`, `br_ne_o`, `jump_o` and `use_shamt_o` to 0, `alu_op_o` to 0 and `alu_src_imm_o` to 0.
- R13: These words decode as listed:
  - 0x012A4020 → register add, destination 8, sources 9 and 10;
  - 0x8D09000C → load word to register 9, base 8, offset 12;
  - 0x22D5FFCE → add-immediate, destination 21, source 22, immediate 0xFFFFFFCE;
  - 0x00094100 → shift left, operand register 9, destination 8, distance 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| fmt_o | output | 2 | Layout: 0 register, 1 immediate, 2 jump |
| rs_addr_o | output | 5 | First read register address |
| rt_addr_o | output | 5 | Second read register address |
| wr_addr_o | output | 5 | Destination register address |
| reg_we_o | output | 1 | Register write enable |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| shamt_o | output | 5 | Shift distance field |
| use_shamt_o | output | 1 | Shift distance comes from `shamt_o` |
| imm_o | output | 32 | Extended immediate |
| jump_index_o | output | 26 | Jump target field |
| mem_rd_o | output | 1 | Load |
| mem_wr_o | output | 1 | Store |
| br_eq_o | output | 1 | Branch if equal |
| br_ne_o | output | 1 | Branch if not equal |
| jump_o | output | 1 | Unconditional jump |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The block holds no state, so an internal fault shows at the ports as soon as the offending word is applied. A wrong table entry shows up in the same cycle as a wrong ALU code, a wrong destination select or a missing flag.

The faults most likely to hide are these:
- a wrong extension mode, which is visible only when bit 15 of the immediate is set;
- a missed illegal case, which is visible only when an unlisted opcode or function code meets a write enable.

The stimulus therefore aims at negative immediates and at raw random words.

// File: rtl/insn32_decoder_pkg.sv
package insn32_decoder_pkg;

    localparam int OPC_W   = 6;
    localparam int REG_AW  = 5;
    localparam int SHAMT_W = 5;
    localparam int FUNCT_W = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    typedef enum logic [1:0] {
        FMT_REG = 2'd0,
        FMT_IMM = 2'd1,
        FMT_JMP = 2'd2
    } fmt_e;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_AND   = 4'd2,
        ALU_OR    = 4'd3,
        ALU_NOR   = 4'd4,
        ALU_SLT   = 4'd5,
        ALU_SLL   = 4'd6,
        ALU_SRL   = 4'd7,
        ALU_XOR   = 4'd8,
        ALU_PASSB = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN  = 2'd0,
        IMM_ZERO  = 2'd1,
        IMM_UPPER = 2'd2
    } imm_mode_e;

    // major opcodes
    localparam logic [OPC_W-1:0] OPC_REGOP = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE  = 6'd5;
    localparam logic [OPC_W-1:0] OPC_ADDK  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTK  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ANDK  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORK   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_XORK  = 6'd14;
    localparam logic [OPC_W-1:0] OPC_UPPK  = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

    // function codes under OPC_REGOP
    localparam logic [FUNCT_W-1:0] FN_SHL  = 6'd0;
    localparam logic [FUNCT_W-1:0] FN_SHR  = 6'd2;
    localparam logic [FUNCT_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_AND  = 6'd36;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'd37;
    localparam logic [FUNCT_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FUNCT_W-1:0] FN_SLT  = 6'd42;

    typedef struct packed {
        fmt_e      fmt;
        alu_op_e   alu_op;
        imm_mode_e imm_mode;
        logic      dst_is_rd;
        logic      reg_we;
        logic      src_imm;
        logic      use_shamt;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      illegal;
    } ctrl_t;

endpackage

// File: rtl/insn_fields.sv
module insn_fields
    import insn32_decoder_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    word_i,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [REG_AW-1:0]  rs_o,
    output logic [REG_AW-1:0]  rt_o,
    output logic [REG_AW-1:0]  rd_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic [FUNCT_W-1:0] funct_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [TGT_W-1:0]   tgt_o
);
    // Field positions are fixed by the encoding; offsets derived from widths.
    localparam int FN_LO  = 0;
    localparam int SH_LO  = FN_LO + FUNCT_W;
    localparam int RD_LO  = SH_LO + SHAMT_W;
    localparam int RT_LO  = RD_LO + REG_AW;
    localparam int RS_LO  = RT_LO + REG_AW;
    localparam int OPC_LO = RS_LO + REG_AW;

    assign opcode_o = word_i[OPC_LO +: OPC_W];
    assign rs_o     = word_i[RS_LO  +: REG_AW];
    assign rt_o     = word_i[RT_LO  +: REG_AW];
    assign rd_o     = word_i[RD_LO  +: REG_AW];
    assign shamt_o  = word_i[SH_LO  +: SHAMT_W];
    assign funct_o  = word_i[FN_LO  +: FUNCT_W];
    assign imm_o    = word_i[0 +: IMM_W];
    assign tgt_o    = word_i[0 +: TGT_W];
endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
    import insn32_decoder_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output ctrl_t              ctrl_o
);
    ctrl_t c;

    always_comb begin
        c          = '0;
        c.fmt      = FMT_IMM;
        c.alu_op   = ALU_ADD;
        c.imm_mode = IMM_SIGN;
        unique case (opcode_i)
            OPC_REGOP: begin
                c.fmt       = FMT_REG;
                c.dst_is_rd = 1'b1;
                c.reg_we    = 1'b1;
                unique case (funct_i)
                    FN_ADD: c.alu_op = ALU_ADD;
                    FN_SUB: c.alu_op = ALU_SUB;
                    FN_AND: c.alu_op = ALU_AND;
                    FN_OR:  c.alu_op = ALU_OR;
                    FN_NOR: c.alu_op = ALU_NOR;
                    FN_SLT: c.alu_op = ALU_SLT;
                    FN_SHL: begin c.alu_op = ALU_SLL; c.use_shamt = 1'b1; end
                    FN_SHR: begin c.alu_op = ALU_SRL; c.use_shamt = 1'b1; end
                    default: begin
                        c.illegal = 1'b1;
                        c.reg_we  = 1'b0;
                    end
                endcase
            end
            OPC_JUMP: begin
                c.fmt  = FMT_JMP;
                c.jump = 1'b1;
            end
            OPC_BREQ: begin c.alu_op = ALU_SUB; c.br_eq = 1'b1; end
            OPC_BRNE: begin c.alu_op = ALU_SUB; c.br_ne = 1'b1; end
            OPC_ADDK: begin c.reg_we = 1'b1; c.src_imm = 1'b1; end
            OPC_SLTK: begin c.alu_op = ALU_SLT; c.reg_we = 1'b1; c.src_imm = 1'b1; end
            OPC_ANDK: begin
                c.alu_op = ALU_AND; c.reg_we = 1'b1; c.src_imm = 1'b1;
                c.imm_mode = IMM_ZERO;
            end
            OPC_ORK: begin
                c.alu_op = ALU_OR; c.reg_we = 1'b1; c.src_imm = 1'b1;
                c.imm_mode = IMM_ZERO;
            end
            OPC_XORK: begin
                c.alu_op = ALU_XOR; c.reg_we = 1'b1; c.src_imm = 1'b1;
                c.imm_mode = IMM_ZERO;
            end
            OPC_UPPK: begin
                c.alu_op = ALU_PASSB; c.reg_we = 1'b1; c.src_imm = 1'b1;
                c.imm_mode = IMM_UPPER;
            end
            OPC_LOAD: begin
                c.reg_we = 1'b1; c.src_imm = 1'b1; c.mem_rd = 1'b1;
            end
            OPC_STORE: begin
                c.src_imm = 1'b1; c.mem_wr = 1'b1;
            end
            default: c.illegal = 1'b1;
        endcase
    end

    assign ctrl_o = c;
endmodule

// File: rtl/insn_imm_gen.sv
module insn_imm_gen
    import insn32_decoder_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [IMM_W-1:0] imm_i,
    input  imm_mode_e        mode_i,
    output logic [XLEN-1:0]  ext_o
);
    localparam int PAD = XLEN - IMM_W;

    always_comb begin
        unique case (mode_i)
            IMM_SIGN:  ext_o = {{PAD{imm_i[IMM_W-1]}}, imm_i};
            IMM_ZERO:  ext_o = {{PAD{1'b0}}, imm_i};
            IMM_UPPER: ext_o = {imm_i, {PAD{1'b0}}};
            default:   ext_o = '0;
        endcase
    end
endmodule

// File: rtl/insn32_decoder.sv
module insn32_decoder
    import insn32_decoder_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    instr_i,
    output logic [1:0]         fmt_o,
    output logic [REG_AW-1:0]  rs_addr_o,
    output logic [REG_AW-1:0]  rt_addr_o,
    output logic [REG_AW-1:0]  wr_addr_o,
    output logic               reg_we_o,
    output logic [3:0]         alu_op_o,
    output logic               alu_src_imm_o,
    output logic [SHAMT_W-1:0] shamt_o,
    output logic               use_shamt_o,
    output logic [XLEN-1:0]    imm_o,
    output logic [TGT_W-1:0]   jump_index_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               br_eq_o,
    output logic               br_ne_o,
    output logic               jump_o,
    output logic               illegal_o
);
    logic [OPC_W-1:0]   opcode;
    logic [REG_AW-1:0]  rd;
    logic [FUNCT_W-1:0] funct;
    logic [IMM_W-1:0]   imm_raw;
    ctrl_t              ctrl;

    insn_fields #(.XLEN(XLEN)) u_fields (
        .word_i  (instr_i),
        .opcode_o(opcode),
        .rs_o    (rs_addr_o),
        .rt_o    (rt_addr_o),
        .rd_o    (rd),
        .shamt_o (shamt_o),
        .funct_o (funct),
        .imm_o   (imm_raw),
        .tgt_o   (jump_index_o)
    );

    insn_ctrl_decode u_ctrl (
        .opcode_i(opcode),
        .funct_i (funct),
        .ctrl_o  (ctrl)
    );

    insn_imm_gen #(.XLEN(XLEN)) u_imm (
        .imm_i (imm_raw),
        .mode_i(ctrl.imm_mode),
        .ext_o (imm_o)
    );

    assign fmt_o         = ctrl.fmt;
    assign wr_addr_o     = ctrl.dst_is_rd ? rd : rt_addr_o;
    assign reg_we_o      = ctrl.reg_we;
    assign alu_op_o      = ctrl.alu_op;
    assign alu_src_imm_o = ctrl.src_imm;
    assign use_shamt_o   = ctrl.use_shamt;
    assign mem_rd_o      = ctrl.mem_rd;
    assign mem_wr_o      = ctrl.mem_wr;
    assign br_eq_o       = ctrl.br_eq;
    assign br_ne_o       = ctrl.br_ne;
    assign jump_o        = ctrl.jump;
    assign illegal_o     = ctrl.illegal;

    // Checks across the field splitter, control table and immediate unit.
    always_comb begin
        if (!$isunknown(instr_i)) begin
            a_r12_illegal_silent: assert (!illegal_o ||
                !(reg_we_o || mem_rd_o || mem_wr_o || br_eq_o || br_ne_o || jump_o))
                else $error("R12: illegal word produced a side effect");
            a_r9_single_effect: assert ($onehot0({mem_rd_o, mem_wr_o, br_eq_o, br_ne_o, jump_o}))
                else $error("R9: more than one control-flow/memory flag");
            a_r10_no_write_on_flow: assert (!(mem_wr_o || br_eq_o || br_ne_o || jump_o) || !reg_we_o)
                else $error("R10: write enable with store/branch/jump");
            a_r7_zero_ext_upper: assert (ctrl.imm_mode != IMM_ZERO || imm_o[XLEN-1:IMM_W] == '0)
                else $error("R7: zero-extended immediate has upper bits set");
            a_r8_upper_low_clear: assert (ctrl.imm_mode != IMM_UPPER || imm_o[IMM_W-1:0] == '0)
                else $error("R8: upper immediate has lower bits set");
            a_r4_shift_reg_fmt: assert (!use_shamt_o || fmt_o == FMT_REG)
                else $error("R4: shift distance used outside register layout");
            a_r3_reg_dest: assert (fmt_o != FMT_REG || illegal_o || wr_addr_o == instr_i[15:11])
                else $error("R3: register layout destination not bits 15:11");
        end
    end
endmodule

// File: tb/insn32_decoder_tb.sv
module insn32_decoder_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] instr;
    logic [1:0]  fmt;
    logic [4:0]  rs_addr, rt_addr, wr_addr, shamt;
    logic        reg_we, alu_src_imm, use_shamt;
    logic [3:0]  alu_op;
    logic [31:0] imm;
    logic [25:0] jidx;
    logic        mem_rd, mem_wr, br_eq, br_ne, jump, illegal;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    insn32_decoder u_dut (
        .instr_i      (instr),
        .fmt_o        (fmt),
        .rs_addr_o    (rs_addr),
        .rt_addr_o    (rt_addr),
        .wr_addr_o    (wr_addr),
        .reg_we_o     (reg_we),
        .alu_op_o     (alu_op),
        .alu_src_imm_o(alu_src_imm),
        .shamt_o      (shamt),
        .use_shamt_o  (use_shamt),
        .imm_o        (imm),
        .jump_index_o (jidx),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .br_eq_o      (br_eq),
        .br_ne_o      (br_ne),
        .jump_o       (jump),
        .illegal_o    (illegal)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic [4:0]  wr;
        logic        we;
        logic [3:0]  aop;
        logic        src;
        logic        sh;
        logic [31:0] imm;
        logic        mr, mw, be, bn, j, ill;
    } exp_t;

    function automatic exp_t model(logic [31:0] w);
        exp_t        e;
        logic [5:0]  op = w[31:26];
        logic [5:0]  fn = w[5:0];
        logic [15:0] k  = w[15:0];
        e     = '0;
        e.fmt = 2'd1;
        e.wr  = w[20:16];
        e.imm = {{16{k[15]}}, k};
        case (op)
            6'd0: begin
                e.fmt = 2'd0; e.wr = w[15:11]; e.we = 1'b1;
                case (fn)
                    6'd32: e.aop = 4'd0;
                    6'd34: e.aop = 4'd1;
                    6'd36: e.aop = 4'd2;
                    6'd37: e.aop = 4'd3;
                    6'd39: e.aop = 4'd4;
                    6'd42: e.aop = 4'd5;
                    6'd0:  begin e.aop = 4'd6; e.sh = 1'b1; end
                    6'd2:  begin e.aop = 4'd7; e.sh = 1'b1; end
                    default: begin e.ill = 1'b1; e.we = 1'b0; end
                endcase
            end
            6'd2:  begin e.fmt = 2'd2; e.j = 1'b1; end
            6'd4:  begin e.aop = 4'd1; e.be = 1'b1; end
            6'd5:  begin e.aop = 4'd1; e.bn = 1'b1; end
            6'd8:  begin e.we = 1'b1; e.src = 1'b1; end
            6'd10: begin e.aop = 4'd5; e.we = 1'b1; e.src = 1'b1; end
            6'd12: begin e.aop = 4'd2; e.we = 1'b1; e.src = 1'b1; e.imm = {16'h0, k}; end
            6'd13: begin e.aop = 4'd3; e.we = 1'b1; e.src = 1'b1; e.imm = {16'h0, k}; end
            6'd14: begin e.aop = 4'd8; e.we = 1'b1; e.src = 1'b1; e.imm = {16'h0, k}; end
            6'd15: begin e.aop = 4'd9; e.we = 1'b1; e.src = 1'b1; e.imm = {k, 16'h0}; end
            6'd35: begin e.we = 1'b1; e.src = 1'b1; e.mr = 1'b1; end
            6'd43: begin e.src = 1'b1; e.mw = 1'b1; end
            default: e.ill = 1'b1;
        endcase
        return e;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w);
        exp_t e;
        @(negedge clk);
        instr = w;
        #1;
        e = model(w);
        chk("R2",  "fmt",       {30'd0, fmt},         {30'd0, e.fmt});
        chk("R1",  "rs",        {27'd0, rs_addr},     {27'd0, w[25:21]});
        chk("R1",  "rt",        {27'd0, rt_addr},     {27'd0, w[20:16]});
        chk("R1",  "shamt",     {27'd0, shamt},       {27'd0, w[10:6]});
        chk("R1",  "jidx",      {6'd0, jidx},         {6'd0, w[25:0]});
        chk("R5",  "wr_addr",   {27'd0, wr_addr},     {27'd0, e.wr});
        chk("R5",  "alu_src",   {31'd0, alu_src_imm}, {31'd0, e.src});
        chk("R3",  "alu_op",    {28'd0, alu_op},      {28'd0, e.aop});
        chk("R4",  "use_shamt", {31'd0, use_shamt},   {31'd0, e.sh});
        chk("R6",  "imm",       imm,                  e.imm);
        chk("R9",  "mem_flags", {30'd0, mem_rd, mem_wr}, {30'd0, e.mr, e.mw});
        chk("R10", "br_flags",  {30'd0, br_eq, br_ne},   {30'd0, e.be, e.bn});
        chk("R11", "jump",      {31'd0, jump},        {31'd0, e.j});
        chk("R12", "reg_we",    {31'd0, reg_we},      {31'd0, e.we});
        chk("R12", "illegal",   {31'd0, illegal},     {31'd0, e.ill});
    endtask

    localparam logic [5:0] OPS [12] = '{6'd0, 6'd2, 6'd4, 6'd5, 6'd8, 6'd10,
                                        6'd12, 6'd13, 6'd14, 6'd15, 6'd35, 6'd43};
    localparam logic [5:0] FNS [8]  = '{6'd32, 6'd34, 6'd36, 6'd37,
                                        6'd39, 6'd42, 6'd0, 6'd2};

    initial begin
        logic [31:0] seed_val;
        instr = 32'h0;
        seed_val = $urandom(32'h5EED_C0DE);

        // all-zero word: shift left of register 0 by 0, legal
        apply(32'h0000_0000);
        chk("R4", "zero word shift", {31'd0, use_shamt}, 32'd1);

        // R13 example words
        apply(32'h012A_4020);
        chk("R13", "add rs", {27'd0, rs_addr}, 32'd9);
        chk("R13", "add rt", {27'd0, rt_addr}, 32'd10);
        chk("R13", "add wr", {27'd0, wr_addr}, 32'd8);
        chk("R13", "add op", {28'd0, alu_op},  32'd0);
        apply(32'h8D09_000C);
        chk("R13", "load wr",  {27'd0, wr_addr}, 32'd9);
        chk("R13", "load imm", imm,              32'd12);
        chk("R13", "load rd",  {31'd0, mem_rd},  32'd1);
        apply(32'h22D5_FFCE);
        chk("R13", "addk wr",  {27'd0, wr_addr}, 32'd21);
        chk("R13", "addk rs",  {27'd0, rs_addr}, 32'd22);
        chk("R13", "addk imm", imm,              32'hFFFF_FFCE);
        apply(32'h0009_4100);
        chk("R13", "shl rt",    {27'd0, rt_addr}, 32'd9);
        chk("R13", "shl wr",    {27'd0, wr_addr}, 32'd8);
        chk("R13", "shl shamt", {27'd0, shamt},   32'd4);
        chk("R13", "shl op",    {28'd0, alu_op},  32'd6);

        // R7 zero extension with bit 15 set (and-immediate, xor-immediate)
        apply(32'h3000_8001);
        chk("R7", "andk imm", imm, 32'h0000_8001);
        apply(32'h3800_FFFF);
        chk("R7", "xork imm", imm, 32'h0000_FFFF);
        // R8 upper placement
        apply(32'h3C01_ABCD);
        chk("R8", "upper imm", imm, 32'hABCD_0000);
        // R6 negative branch offset
        apply(32'h1000_FFFF);
        chk("R6", "branch imm", imm, 32'hFFFF_FFFF);
        // R9 store, negative offset, no write
        apply(32'hAD09_FFF8);
        chk("R9", "store we",  {31'd0, reg_we}, 32'd0);
        chk("R9", "store imm", imm, 32'hFFFF_FFF8);
        // R11 jump
        apply(32'h0800_0002);
        chk("R11", "jump we", {31'd0, reg_we}, 32'd0);
        // R12 unsupported funct and opcode
        apply(32'h0000_003F);
        chk("R12", "bad funct", {31'd0, illegal}, 32'd1);
        apply(32'hFC00_0000);
        chk("R12", "bad opcode", {31'd0, illegal}, 32'd1);

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [31:0] w;
            w = $urandom();
            if ($urandom_range(0, 3) != 0) begin
                w[31:26] = OPS[$urandom_range(0, 11)];
                if (w[31:26] == 6'd0 && $urandom_range(0, 3) != 0)
                    w[5:0] = FNS[$urandom_range(0, 7)];
            end
            apply(w);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule